// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block sits in front of the priority resolver of one eight-line interrupt controller. It takes byte writes and reads on a two-port register window and turns them into resolver controls: the interrupt mask, the vector base, the mode bits, priority-offset loads, in-service clear strobes and poll acknowledges. It also returns the byte for each read.

Port select 0 is the command port and port select 1 is the data port. A command-port write with bit 4 set starts a configuration sequence of two or three further data-port writes. A command-port write with bit 4 clear is a run-time command. If bit 3 is set it is a read and poll control word. If bit 3 is clear, bits 7:5 carry an end-of-interrupt or rotation opcode. The resolver reports its request and in-service registers, the line that would win arbitration now, and the highest-priority line in service. The decoder reads these inputs only when a command or a poll needs them.

Every resolver action is a registered strobe. It is high for exactly the one cycle after the write or read that caused it, and the resolver applies it on the next clock edge. Single-controller mode and level-trigger selection in the configuration word are not supported. Either request raises a one-cycle flag and has no other effect.

Top module: `intc_cmd_decoder`

## Requirements
- R1: Synchronous active-low reset clears the mask, the base, nested mode, auto-EOI, rotate-on-auto-EOI and special mask. It selects the request register for command-port reads, clears poll and all strobes, and leaves the configuration sequence idle.
- R2: A command-port write with bit 4 set raises `init_clr` for one cycle. It clears the mask, the base and the four mode bits, and it latches bit 0 as "final mode word expected".
- R3: The first data-port write after R2 sets `base_out` to the written byte AND 0xF8.
- R4: The second data-port write is discarded. If a final mode word is expected, a third write sets `nested_mode` from bit 4 and `auto_eoi` from bit 1. In both cases the next data-port write after the sequence loads the mask.
- R5: In the bit-4 command write, bit 1 (single mode) or bit 3 (level mode) raises `cfg_unsup` for one cycle and does not change the sequence. With both bits clear, `cfg_unsup` stays low.
- R6: Outside the configuration sequence, a data-port write loads `mask_out`, and a data-port read returns the mask.
- R7: A command write with bit 4 clear and bit 3 set updates the read select only when bit 1 is set. Bit 0 = 1 picks the in-service register and bit 0 = 0 picks the request register. A command-port read that is not a poll returns the selected register.
- R8: In the same command word, bit 6 set loads `special_mask` from bit 5, and bit 6 clear leaves it unchanged.
- R9: A command write with bits 4:3 = 00 uses bits 7:5 as the opcode. Opcode 0 clears `rot_auto_eoi`, opcode 4 sets it, and opcode 2 causes no action.
- R10: Opcode 1 clears the highest-priority in-service line reported by the resolver (`eoi_stb`, `eoi_line`). When no line is in service it does nothing. Opcode 5 does the same and also loads the offset with that line + 1 modulo 8.
- R11: Opcode 3 clears in-service line bits 2:0. Opcode 7 does the same and also loads the offset with that line + 1. Opcode 6 only loads the offset with bits 2:0 + 1 modulo 8.
- R12: Command bit 2 arms a poll. The next read on either port returns the winning line, or 0x07 if none wins, and disarms the poll. A winning line also gets a one-cycle `poll_ack` with `poll_line` on the following cycle.
- R13: Every strobe is high in the single cycle after the access that caused it and low in the next cycle unless a new access re-raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel | input | 1 | 0 = command port, 1 = data port |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wr_data | input | 8 | Write byte |
| res_irr | input | 8 | Resolver request register |
| res_isr | input | 8 | Resolver in-service register |
| win_valid | input | 1 | A line would win arbitration now |
| win_line | input | 3 | The winning line |
| top_isr_valid | input | 1 | At least one line is in service |
| top_isr_line | input | 3 | Highest-priority in-service line |
| rd_data | output | 8 | Read byte (combinational, valid while rd_en) |
| mask_out | output | 8 | Interrupt mask |
| base_out | output | 8 | Vector base, low three bits zero |
| nested_mode | output | 1 | Special nested mode |
| auto_eoi | output | 1 | Automatic end of interrupt |
| rot_auto_eoi | output | 1 | Rotate on automatic end of interrupt |
| special_mask | output | 1 | Special mask mode |
| init_clr | output | 1 | Strobe: clear resolver state and drop its output |
| cfg_unsup | output | 1 | Strobe: unsupported configuration bit seen |
| eoi_stb | output | 1 | Strobe: clear one in-service bit |
| eoi_line | output | 3 | Line for eoi_stb |
| ofs_stb | output | 1 | Strobe: load priority offset |
| ofs_val | output | 3 | New priority offset |
| poll_ack | output | 1 | Strobe: clear request and in-service bits of poll_line |
| poll_line | output | 3 | Line for poll_ack |

## Verification
A wrong sequence state shows up on the next data-port write. The byte lands in the mask when it should land in the base or the mode bits, or the other way round, and the mask read-back shows it one access later. A stale read select or poll flag changes the very next command-port read. A wrong opcode decode shows up in the strobe pattern in the cycle after the write: a strobe is missing, a line number is wrong, or the offset value is wrong. The bench therefore checks every strobe in that cycle and checks the mode registers at the same point.

// File: rtl/icp_pkg.sv
// Package: shared constants and types for the interrupt controller command decoder.
// Assumes byte-wide registers with one bit per interrupt line.
package icp_pkg;
    localparam int unsigned CFG_START_BIT  = 4;   // command word: begin configuration
    localparam int unsigned OCW_SEL_BIT    = 3;   // command word: read/poll control
    localparam int unsigned CFG_FINAL_BIT  = 0;   // first config word: final mode word expected
    localparam int unsigned CFG_SINGLE_BIT = 1;   // first config word: single controller
    localparam int unsigned CFG_LEVEL_BIT  = 3;   // first config word: level trigger
    localparam int unsigned MODE_NEST_BIT  = 4;   // final mode word: nested mode
    localparam int unsigned MODE_AEOI_BIT  = 1;   // final mode word: auto end of interrupt
    localparam int unsigned RC_POLL_BIT    = 2;   // read/poll word: arm poll
    localparam int unsigned RC_RSEN_BIT    = 1;   // read/poll word: update read select
    localparam int unsigned RC_RSISR_BIT   = 0;   // read/poll word: select in-service
    localparam int unsigned RC_SMEN_BIT    = 6;   // read/poll word: update special mask
    localparam int unsigned RC_SMVAL_BIT   = 5;   // read/poll word: special mask value

    typedef enum logic [1:0] {
        CFG_IDLE = 2'd0,
        CFG_BASE = 2'd1,
        CFG_SKIP = 2'd2,
        CFG_MODE = 2'd3
    } cfg_state_t;

    typedef enum logic [2:0] {
        OP_ROT_CLR   = 3'd0,
        OP_EOI_TOP   = 3'd1,
        OP_NOP       = 3'd2,
        OP_EOI_LINE  = 3'd3,
        OP_ROT_SET   = 3'd4,
        OP_EOI_TOP_R = 3'd5,
        OP_SET_OFS   = 3'd6,
        OP_EOI_LINE_R= 3'd7
    } op_code_t;
endpackage

// File: rtl/icp_cfg_seq.sv
// Module: configuration sequencer and data-port register owner.
// Handles the multi-word configuration sequence, the mask register and the
// mode bits. Assumes the caller has already decoded the port and bit 4.
module icp_cfg_seq
    import icp_pkg::*;
#(
    parameter int unsigned LINES = 8,
    localparam int unsigned DW   = LINES,
    localparam int unsigned LW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_start,   // command-port write with bit 4 set
    input  logic          data_wr,     // data-port write
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] base_q,
    output logic          nest_q,
    output logic          aeoi_q,
    output logic          init_clr_q,
    output logic          unsup_q,
    output logic          cfg_busy
);
    localparam logic [DW-1:0] BASE_KEEP = ~DW'(LINES - 1);

    cfg_state_t state_q;
    logic       final_exp_q;

    assign cfg_busy = (state_q != CFG_IDLE);

    // Sequence state, mode latches, mask and base register updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= CFG_IDLE;
            final_exp_q <= 1'b0;
            mask_q      <= '0;
            base_q      <= '0;
            nest_q      <= 1'b0;
            aeoi_q      <= 1'b0;
            init_clr_q  <= 1'b0;
            unsup_q     <= 1'b0;
        end else begin
            init_clr_q <= cfg_start;
            unsup_q    <= cfg_start & (wdata[CFG_SINGLE_BIT] | wdata[CFG_LEVEL_BIT]);
            if (cfg_start) begin
                state_q     <= CFG_BASE;
                final_exp_q <= wdata[CFG_FINAL_BIT];
                mask_q      <= '0;
                base_q      <= '0;
                nest_q      <= 1'b0;
                aeoi_q      <= 1'b0;
            end else if (data_wr) begin
                unique case (state_q)
                    CFG_IDLE: mask_q <= wdata;
                    CFG_BASE: begin
                        base_q  <= wdata & BASE_KEEP;
                        state_q <= CFG_SKIP;
                    end
                    CFG_SKIP: state_q <= final_exp_q ? CFG_MODE : CFG_IDLE;
                    CFG_MODE: begin
                        nest_q  <= wdata[MODE_NEST_BIT];
                        aeoi_q  <= wdata[MODE_AEOI_BIT];
                        state_q <= CFG_IDLE;
                    end
                    default: state_q <= CFG_IDLE;
                endcase
            end
        end
    end

    // R3
    base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CFG_BASE && data_wr && !cfg_start)
        |=> (state_q == CFG_SKIP && base_q[LW-1:0] == '0));

    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && state_q == CFG_IDLE) && !cfg_start |=> $stable(mask_q));

    // R2
    init_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr_q |-> (state_q == CFG_BASE && mask_q == '0 && !nest_q && !aeoi_q));
endmodule

// File: rtl/icp_op_ctl.sv
// Module: run-time command decoder.
// Decodes end-of-interrupt/rotation opcodes and read/poll control words into
// registered one-cycle strobes and mode latches. Assumes the resolver status
// inputs are valid in the cycle of the access.
module icp_op_ctl
    import icp_pkg::*;
#(
    parameter int unsigned LINES = 8,
    localparam int unsigned DW   = LINES,
    localparam int unsigned LW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_start,
    input  logic          rc_wr,       // read/poll control word
    input  logic          op_wr,       // opcode word
    input  logic [DW-1:0] wdata,
    input  logic          poll_rd,     // read while poll armed
    input  logic          win_v,
    input  logic [LW-1:0] win_l,
    input  logic          top_v,
    input  logic [LW-1:0] top_l,
    output logic          rs_isr_q,
    output logic          poll_q,
    output logic          smask_q,
    output logic          rot_q,
    output logic          eoi_q,
    output logic [LW-1:0] eoi_line_q,
    output logic          ofs_q,
    output logic [LW-1:0] ofs_val_q,
    output logic          pack_q,
    output logic [LW-1:0] pack_line_q
);
    op_code_t      op;
    logic [LW-1:0] wline;

    assign op    = op_code_t'(wdata[DW-1 -: 3]);
    assign wline = wdata[LW-1:0];

    // Strobes and mode latches driven by writes and poll reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rs_isr_q    <= 1'b0;
            poll_q      <= 1'b0;
            smask_q     <= 1'b0;
            rot_q       <= 1'b0;
            eoi_q       <= 1'b0;
            eoi_line_q  <= '0;
            ofs_q       <= 1'b0;
            ofs_val_q   <= '0;
            pack_q      <= 1'b0;
            pack_line_q <= '0;
        end else begin
            eoi_q  <= 1'b0;
            ofs_q  <= 1'b0;
            pack_q <= 1'b0;
            if (poll_rd) begin
                poll_q <= 1'b0;
                if (win_v) begin
                    pack_q      <= 1'b1;
                    pack_line_q <= win_l;
                end
            end
            if (cfg_start) begin
                rs_isr_q <= 1'b0;
                poll_q   <= 1'b0;
                smask_q  <= 1'b0;
                rot_q    <= 1'b0;
            end else if (rc_wr) begin
                if (wdata[RC_POLL_BIT]) poll_q   <= 1'b1;
                if (wdata[RC_RSEN_BIT]) rs_isr_q <= wdata[RC_RSISR_BIT];
                if (wdata[RC_SMEN_BIT]) smask_q  <= wdata[RC_SMVAL_BIT];
            end else if (op_wr) begin
                unique case (op)
                    OP_ROT_CLR, OP_ROT_SET: rot_q <= op[2];
                    OP_EOI_TOP, OP_EOI_TOP_R: begin
                        if (top_v) begin
                            eoi_q      <= 1'b1;
                            eoi_line_q <= top_l;
                            if (op == OP_EOI_TOP_R) begin
                                ofs_q     <= 1'b1;
                                ofs_val_q <= top_l + 1'b1;
                            end
                        end
                    end
                    OP_EOI_LINE, OP_EOI_LINE_R: begin
                        eoi_q      <= 1'b1;
                        eoi_line_q <= wline;
                        if (op == OP_EOI_LINE_R) begin
                            ofs_q     <= 1'b1;
                            ofs_val_q <= wline + 1'b1;
                        end
                    end
                    OP_SET_OFS: begin
                        ofs_q     <= 1'b1;
                        ofs_val_q <= wline + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // R12
    poll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_rd && !rc_wr) |=> !poll_q);

    // R10
    eoi_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_q |-> $past(op_wr));

    // R12
    pack_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pack_q |-> ($past(poll_rd) && $past(win_v)));
endmodule

// File: rtl/icp_rd_mux.sv
// Module: read data selection.
// Returns the poll result, the mask, or the selected resolver register.
// Purely combinational; assumes rd_data is sampled while the read is active.
module icp_rd_mux #(
    parameter int unsigned LINES = 8,
    localparam int unsigned DW   = LINES,
    localparam int unsigned LW   = $clog2(LINES)
) (
    input  logic          port_sel,
    input  logic          poll_q,
    input  logic          rs_isr_q,
    input  logic          win_v,
    input  logic [LW-1:0] win_l,
    input  logic [DW-1:0] mask_q,
    input  logic [DW-1:0] irr,
    input  logic [DW-1:0] isr,
    output logic [DW-1:0] rd_data
);
    localparam logic [DW-1:0] NO_WIN = DW'(LINES - 1);

    logic [DW-1:0] poll_byte;

    // Poll result: winning line zero-extended, or the lowest-priority code.
    always_comb begin
        poll_byte = win_v ? {{(DW-LW){1'b0}}, win_l} : NO_WIN;
    end

    // Final read selection by poll state and port.
    always_comb begin
        if (poll_q)        rd_data = poll_byte;
        else if (port_sel) rd_data = mask_q;
        else if (rs_isr_q) rd_data = isr;
        else               rd_data = irr;
    end
endmodule

// File: rtl/intc_cmd_decoder.sv
// Module: top of the interrupt controller command decoder.
// Splits each access into configuration start, data write, read/poll word or
// opcode word, and wires the sequencer, opcode controller and read mux.
// Assumes at most one of wr_en and rd_en is set per cycle.
module intc_cmd_decoder
    import icp_pkg::*;
#(
    parameter int unsigned LINES = 8,
    localparam int unsigned DW   = LINES,
    localparam int unsigned LW   = $clog2(LINES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          port_sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] res_irr,
    input  logic [DW-1:0] res_isr,
    input  logic          win_valid,
    input  logic [LW-1:0] win_line,
    input  logic          top_isr_valid,
    input  logic [LW-1:0] top_isr_line,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] mask_out,
    output logic [DW-1:0] base_out,
    output logic          nested_mode,
    output logic          auto_eoi,
    output logic          rot_auto_eoi,
    output logic          special_mask,
    output logic          init_clr,
    output logic          cfg_unsup,
    output logic          eoi_stb,
    output logic [LW-1:0] eoi_line,
    output logic          ofs_stb,
    output logic [LW-1:0] ofs_val,
    output logic          poll_ack,
    output logic [LW-1:0] poll_line
);
    logic cmd_wr, cfg_start, data_wr, rc_wr, op_wr, poll_rd;
    logic rs_isr_q, poll_q, cfg_busy;

    // Access classification by port and command bits.
    always_comb begin
        cmd_wr    = wr_en & ~port_sel;
        cfg_start = cmd_wr &  wr_data[CFG_START_BIT];
        rc_wr     = cmd_wr & ~wr_data[CFG_START_BIT] &  wr_data[OCW_SEL_BIT];
        op_wr     = cmd_wr & ~wr_data[CFG_START_BIT] & ~wr_data[OCW_SEL_BIT];
        data_wr   = wr_en & port_sel;
        poll_rd   = rd_en & poll_q;
    end

    icp_cfg_seq #(.LINES(LINES)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_start  (cfg_start),
        .data_wr    (data_wr),
        .wdata      (wr_data),
        .mask_q     (mask_out),
        .base_q     (base_out),
        .nest_q     (nested_mode),
        .aeoi_q     (auto_eoi),
        .init_clr_q (init_clr),
        .unsup_q    (cfg_unsup),
        .cfg_busy   (cfg_busy)
    );

    icp_op_ctl #(.LINES(LINES)) u_op (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_start   (cfg_start),
        .rc_wr       (rc_wr),
        .op_wr       (op_wr),
        .wdata       (wr_data),
        .poll_rd     (poll_rd),
        .win_v       (win_valid),
        .win_l       (win_line),
        .top_v       (top_isr_valid),
        .top_l       (top_isr_line),
        .rs_isr_q    (rs_isr_q),
        .poll_q      (poll_q),
        .smask_q     (special_mask),
        .rot_q       (rot_auto_eoi),
        .eoi_q       (eoi_stb),
        .eoi_line_q  (eoi_line),
        .ofs_q       (ofs_stb),
        .ofs_val_q   (ofs_val),
        .pack_q      (poll_ack),
        .pack_line_q (poll_line)
    );

    icp_rd_mux #(.LINES(LINES)) u_rd (
        .port_sel (port_sel),
        .poll_q   (poll_q),
        .rs_isr_q (rs_isr_q),
        .win_v    (win_valid),
        .win_l    (win_line),
        .mask_q   (mask_out),
        .irr      (res_irr),
        .isr      (res_isr),
        .rd_data  (rd_data)
    );

    // R13
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_clr |-> !(eoi_stb || ofs_stb));

    // R1
    busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> cfg_busy);
endmodule

// File: tb/tb_intc_cmd_decoder.sv
`timescale 1ns/1ps
module tb_intc_cmd_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       port_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wr_data = '0, res_irr = '0, res_isr = '0;
    logic       win_valid = 1'b0, top_isr_valid = 1'b0;
    logic [2:0] win_line = '0, top_isr_line = '0;
    logic [7:0] rd_data, mask_out, base_out;
    logic       nested_mode, auto_eoi, rot_auto_eoi, special_mask;
    logic       init_clr, cfg_unsup, eoi_stb, ofs_stb, poll_ack;
    logic [2:0] eoi_line, ofs_val, poll_line;

    int n_chk = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    intc_cmd_decoder dut (.*);

    // Entry: {wdata, top_v, top_l, exp_eoi, exp_eline, exp_ofs, exp_oval, exp_rot}
    localparam int NV = 10;
    localparam logic [20:0] OPV [NV] = '{
        {8'h20, 1'b1, 3'd5, 1'b1, 3'd5, 1'b0, 3'd0, 1'b0},
        {8'h20, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0},
        {8'hA0, 1'b1, 3'd7, 1'b1, 3'd7, 1'b1, 3'd0, 1'b0},
        {8'h63, 1'b0, 3'd0, 1'b1, 3'd3, 1'b0, 3'd0, 1'b0},
        {8'hE6, 1'b0, 3'd0, 1'b1, 3'd6, 1'b1, 3'd7, 1'b0},
        {8'hC4, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd5, 1'b0},
        {8'hC7, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1, 3'd0, 1'b0},
        {8'h40, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0},
        {8'h80, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b1},
        {8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0, 3'd0, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic p, input logic [7:0] d);
        @(negedge clk);
        port_sel = p; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic p, output logic [7:0] v);
        @(negedge clk);
        port_sel = p; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        res_irr = 8'h5A; res_isr = 8'hC3;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 mask", mask_out, 8'h00);
        chk("R1 base", base_out, 8'h00);
        chk("R1 modes", {nested_mode, auto_eoi, rot_auto_eoi, special_mask}, 4'b0);
        chk("R1 strobes", {init_clr, cfg_unsup, eoi_stb, ofs_stb, poll_ack}, 5'b0);
        rd(1'b0, v);
        chk("R1 R7 default read irr", v, 8'h5A);

        // R2 R3 R4 sequence with final word
        wr(1'b0, 8'h11);
        chk("R2 init_clr pulse", init_clr, 1'b1);
        chk("R5 no unsupported flag", cfg_unsup, 1'b0);
        @(negedge clk);
        chk("R13 init_clr one cycle", init_clr, 1'b0);
        wr(1'b1, 8'h6D);
        chk("R3 base masked", base_out, 8'h68);
        chk("R4 second word no mask", mask_out, 8'h00);
        wr(1'b1, 8'hFF);
        chk("R4 second word discarded", {base_out, mask_out}, {8'h68, 8'h00});
        wr(1'b1, 8'h12);
        chk("R4 mode bits", {nested_mode, auto_eoi}, 2'b11);
        chk("R4 mode word not mask", mask_out, 8'h00);
        wr(1'b1, 8'hA5);
        chk("R6 mask load", mask_out, 8'hA5);
        rd(1'b1, v);
        chk("R6 mask read", v, 8'hA5);

        // R5 unsupported bits, no final word
        wr(1'b0, 8'h1A);
        chk("R5 unsupported flag", cfg_unsup, 1'b1);
        chk("R2 mask cleared", mask_out, 8'h00);
        chk("R2 modes cleared", {nested_mode, auto_eoi}, 2'b00);
        @(negedge clk);
        chk("R13 cfg_unsup one cycle", cfg_unsup, 1'b0);
        wr(1'b1, 8'h37);
        chk("R5 R3 base still set", base_out, 8'h30);
        wr(1'b1, 8'h00);
        wr(1'b1, 8'h3C);
        chk("R4 no final word mask", mask_out, 8'h3C);
        chk("R4 modes untouched", {nested_mode, auto_eoi}, 2'b00);

        // R9 R10 R11 opcode vectors
        for (int i = 0; i < NV; i++) begin
            logic [20:0] e;
            e = OPV[i];
            top_isr_valid = e[12];
            top_isr_line  = e[11:9];
            wr(1'b0, e[20:13]);
            chk($sformatf("R9 R10 R11 opcode vector %0d", i),
                {eoi_stb, eoi_stb ? eoi_line : 3'd0, ofs_stb, ofs_stb ? ofs_val : 3'd0, rot_auto_eoi},
                {e[8], e[7:5], e[4], e[3:1], e[0]});
            @(negedge clk);
            chk("R13 strobes drop", {eoi_stb, ofs_stb}, 2'b00);
        end
        chk("R10 R11 mask untouched", mask_out, 8'h3C);

        // R7 read select
        wr(1'b0, 8'h0B);
        rd(1'b0, v);
        chk("R7 in-service selected", v, 8'hC3);
        wr(1'b0, 8'h08);
        rd(1'b0, v);
        chk("R7 select held when bit1 clear", v, 8'hC3);
        wr(1'b0, 8'h0A);
        rd(1'b0, v);
        chk("R7 request selected", v, 8'h5A);

        // R8 special mask
        wr(1'b0, 8'h68);
        chk("R8 special mask set", special_mask, 1'b1);
        wr(1'b0, 8'h28);
        chk("R8 special mask held", special_mask, 1'b1);
        wr(1'b0, 8'h48);
        chk("R8 special mask clear", special_mask, 1'b0);

        // R12 poll with winner
        wr(1'b0, 8'h0C);
        win_valid = 1'b1; win_line = 3'd4;
        rd(1'b0, v);
        chk("R12 poll winner", v, 8'h04);
        chk("R12 poll ack", {poll_ack, poll_line}, {1'b1, 3'd4});
        @(negedge clk);
        chk("R13 poll ack one cycle", poll_ack, 1'b0);
        rd(1'b0, v);
        chk("R12 poll disarmed", v, 8'h5A);
        chk("R12 no ack without poll", poll_ack, 1'b0);
        // R12 poll with no winner, data port
        wr(1'b0, 8'h0C);
        win_valid = 1'b0;
        rd(1'b1, v);
        chk("R12 poll none", v, 8'h07);
        chk("R12 no ack when none", poll_ack, 1'b0);

        // R1 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset clears mask and base", {mask_out, base_out}, 16'h0);
        wr(1'b1, 8'h99);
        chk("R1 idle after reset", mask_out, 8'h99);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule